// File: doc/BRIEF.md
# Register-Reference Instruction Execution Unit

This unit carries out the register-reference instructions of a small 16-bit accumulator machine. It owns the accumulator and the one-bit extension flag E. On each execute strobe it examines the instruction word. If that word is a register-reference instruction, the unit updates the accumulator and E, requests a skip of the next instruction when a tested condition holds, and can stop the machine.

The surrounding sequencer presents the instruction register and the current program counter, and raises the strobe for one cycle in the execute step. The skip request and the resulting program-counter value are combinational, so the sequencer can load them in that same cycle. The new accumulator, E and halt state become visible after the clock edge that ends the execute cycle. Each of the twelve low instruction bits selects one operation. When several bits are set, the operations are applied in order from the highest bit to the lowest, all within one cycle.

Top module: `rri_exec_unit`

## Requirements
- R1: After synchronous active-low reset the accumulator is 16'h0000, E is 0, halt is 0 and no skip is requested.
- R2: The unit acts only when exec_stb_i is 1, ir_i[15] is 0 and ir_i[14:12] is 3'b111. In every other cycle the accumulator and E keep their values, skip_o is 0 and pc_next_o equals pc_i.
- R3: Bit ir_i[11] clears the accumulator to zero. Bit ir_i[10] clears E.
- R4: Bit ir_i[9] replaces the accumulator with its bitwise complement. Bit ir_i[8] inverts E.
- R5: Bit ir_i[7] rotates the 17-bit pair {accumulator, E} right by one place: accumulator bit 0 goes to E and the old E goes to accumulator bit 15. Bit ir_i[6] rotates the pair left by one place: accumulator bit 15 goes to E and the old E goes to accumulator bit 0.
- R6: Bit ir_i[5] adds one to the accumulator, wrapping from 16'hFFFF to 16'h0000, and leaves E unchanged.
- R7: In the same cycle as the strobe, skip_o is 1 when any selected test holds. The tests are: ir_i[4], accumulator positive (bit 15 is 0 and the value is nonzero); ir_i[3], accumulator negative (bit 15 is 1); ir_i[2], accumulator zero; ir_i[1], E zero. Each test uses the values produced by the higher-numbered operations of the same instruction.
- R8: pc_next_o equals (pc_i + 1) mod 4096 when skip_o is 1, and pc_i otherwise.
- R9: When several select bits are set, their operations are applied in order from bit 11 down to bit 0 within one cycle.
- R10: Bit ir_i[0] sets halt_o, which then stays 1 until reset. While halt_o is 1, strobes have no effect: the accumulator and E hold and skip_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_i | input | 16 | Instruction register contents |
| exec_stb_i | input | 1 | Execute step of the current instruction |
| pc_i | input | 12 | Program counter, already pointing at the next instruction |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extension flag E |
| skip_o | output | 1 | Skip request for the next instruction, same cycle |
| pc_next_o | output | 12 | Program counter value after any skip |
| halt_o | output | 1 | Sticky halt flag |

## Verification
The assertions check four things on every cycle. Halt never falls once it has risen. The accumulator and E hold in any cycle that does not execute. A skip is never requested outside an executed instruction, and whenever one is requested the program-counter output has moved off pc_i. A lone clear or a lone increment has its stated effect on the accumulator and E. The exact result values can only be shown by the bench's scenarios. These include the rotate bit movement through E, the increment wrap, the four skip conditions at their edges (zero is neither positive nor negative), the program-counter wrap from 12'hFFF, ordering when several select bits combine, and rejection of words with the wrong opcode.

// File: rtl/rri_pkg.sv
// Package rri_pkg
// Shared constants for the register-reference execution unit: the select-bit
// position of each operation (higher position is applied first) and the
// opcode pattern that marks a register-reference instruction.
package rri_pkg;
    localparam int unsigned NUM_OPS = 12;
    localparam logic [2:0]  RRI_OPCODE = 3'b111;

    localparam int unsigned OP_CLA = 11;
    localparam int unsigned OP_CLE = 10;
    localparam int unsigned OP_CMA = 9;
    localparam int unsigned OP_CME = 8;
    localparam int unsigned OP_CIR = 7;
    localparam int unsigned OP_CIL = 6;
    localparam int unsigned OP_INC = 5;
    localparam int unsigned OP_SPA = 4;
    localparam int unsigned OP_SNA = 3;
    localparam int unsigned OP_SZA = 2;
    localparam int unsigned OP_SZE = 1;
    localparam int unsigned OP_HLT = 0;
endpackage

// File: rtl/rri_decode.sv
// Module rri_decode
// Decides whether the current cycle executes a register-reference
// instruction and, if so, passes on the select bits.
// Assumes: the opcode occupies the three bits below the MSB, and the MSB must be 0.
// Select bits are the low NUM_OPS bits of the instruction word.
module rri_decode #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0]           ir_i,
    input  logic                        exec_stb_i,
    input  logic                        halted_i,
    output logic                        fire_o,
    output logic [rri_pkg::NUM_OPS-1:0] sel_o
);
    localparam int unsigned OPC_HI = DATA_W - 2;
    localparam int unsigned OPC_LO = DATA_W - 4;

    logic is_rri;

    // Recognise the register-reference opcode pattern.
    always_comb begin
        is_rri = (ir_i[DATA_W-1] == 1'b0) && (ir_i[OPC_HI:OPC_LO] == rri_pkg::RRI_OPCODE);
    end

    // Gate the select bits with the strobe and the halt state.
    always_comb begin
        fire_o = exec_stb_i && is_rri && !halted_i;
        sel_o  = fire_o ? ir_i[rri_pkg::NUM_OPS-1:0] : '0;
    end
endmodule

// File: rtl/rri_stage.sv
// Module rri_stage
// One link of the ordered operation chain. It applies the single operation
// chosen by OP when en_i is set. Otherwise it passes every value through.
// Assumes: stages are chained from the highest OP down to OP 0, so each
// stage sees the results of all higher-numbered operations.
module rri_stage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OP     = 0
) (
    input  logic              en_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              e_i,
    input  logic              skip_i,
    input  logic              halt_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              e_o,
    output logic              skip_o,
    output logic              halt_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic ac_neg;
    logic ac_zero;

    // Sign and zero tests on the incoming accumulator value.
    always_comb begin
        ac_neg  = ac_i[DATA_W-1];
        ac_zero = (ac_i == '0);
    end

    // Apply this stage's operation or pass values through.
    always_comb begin
        ac_o   = ac_i;
        e_o    = e_i;
        skip_o = skip_i;
        halt_o = halt_i;
        if (en_i) begin
            case (OP)
                rri_pkg::OP_CLA: ac_o = '0;
                rri_pkg::OP_CLE: e_o = 1'b0;
                rri_pkg::OP_CMA: ac_o = ~ac_i;
                rri_pkg::OP_CME: e_o = ~e_i;
                rri_pkg::OP_CIR: begin
                    ac_o = {e_i, ac_i[DATA_W-1:1]};
                    e_o  = ac_i[0];
                end
                rri_pkg::OP_CIL: begin
                    ac_o = {ac_i[DATA_W-2:0], e_i};
                    e_o  = ac_i[DATA_W-1];
                end
                rri_pkg::OP_INC: ac_o = ac_i + ONE;
                rri_pkg::OP_SPA: skip_o = skip_i | (!ac_neg && !ac_zero);
                rri_pkg::OP_SNA: skip_o = skip_i | ac_neg;
                rri_pkg::OP_SZA: skip_o = skip_i | ac_zero;
                rri_pkg::OP_SZE: skip_o = skip_i | !e_i;
                rri_pkg::OP_HLT: halt_o = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rri_exec_unit.sv
// Module rri_exec_unit
// Top of the register-reference execution unit. It holds the accumulator,
// E and the sticky halt flag. Each executed instruction runs through an
// ordered chain of single-operation stages, and the result is registered
// at the clock edge. The skip request and the skipped program counter are
// combinational outputs for the same cycle.
// Assumes: pc_i already points at the instruction after the current one,
// and the address space wraps modulo 2**ADDR_W.
module rri_exec_unit #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ir_i,
    input  logic              exec_stb_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              e_o,
    output logic              skip_o,
    output logic [ADDR_W-1:0] pc_next_o,
    output logic              halt_o
);
    localparam int unsigned NOPS = rri_pkg::NUM_OPS;

    logic [DATA_W-1:0] ac_q;
    logic              e_q;
    logic              halt_q;
    logic              fire;
    logic [NOPS-1:0]   sel;

    logic [DATA_W-1:0] ac_s   [0:NOPS];
    logic              e_s    [0:NOPS];
    logic              skip_s [0:NOPS];
    logic              halt_s [0:NOPS];

    rri_decode #(.DATA_W(DATA_W)) decode_i (
        .ir_i       (ir_i),
        .exec_stb_i (exec_stb_i),
        .halted_i   (halt_q),
        .fire_o     (fire),
        .sel_o      (sel)
    );

    // Feed the chain with the registered state.
    always_comb begin
        ac_s[0]   = ac_q;
        e_s[0]    = e_q;
        skip_s[0] = 1'b0;
        halt_s[0] = 1'b0;
    end

    // Ordered chain: stage k applies select bit NOPS-1-k.
    for (genvar k = 0; k < NOPS; k++) begin : g_chain
        rri_stage #(.DATA_W(DATA_W), .OP(NOPS - 1 - k)) stage_i (
            .en_i   (sel[NOPS-1-k]),
            .ac_i   (ac_s[k]),
            .e_i    (e_s[k]),
            .skip_i (skip_s[k]),
            .halt_i (halt_s[k]),
            .ac_o   (ac_s[k+1]),
            .e_o    (e_s[k+1]),
            .skip_o (skip_s[k+1]),
            .halt_o (halt_s[k+1])
        );
    end

    // Register accumulator, E and sticky halt at the end of the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q   <= '0;
            e_q    <= 1'b0;
            halt_q <= 1'b0;
        end else if (fire) begin
            ac_q   <= ac_s[NOPS];
            e_q    <= e_s[NOPS];
            halt_q <= halt_q | halt_s[NOPS];
        end
    end

    // Same-cycle skip request and skipped program counter.
    always_comb begin
        skip_o    = fire & skip_s[NOPS];
        pc_next_o = pc_i + {{(ADDR_W-1){1'b0}}, skip_o};
        ac_o      = ac_q;
        e_o       = e_q;
        halt_o    = halt_q;
    end

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(ac_o) && $stable(e_o)));

    // R7
    skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (exec_stb_i && !halt_o));

    // R8
    pc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (pc_next_o != pc_i));

    // R3
    cla_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sel == (NOPS'(1) << rri_pkg::OP_CLA)) |=> (ac_o == '0));

    // R6
    inc_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sel == (NOPS'(1) << rri_pkg::OP_INC)) |=> (e_o == $past(e_o)));
endmodule

// File: tb/rri_exec_unit_tb_top.sv
// Scoreboard bench for rri_exec_unit. A driver task models each instruction
// and queues the expected result. A monitor checks the same-cycle skip
// outputs, then the registered state after the clock edge.
module rri_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ir = '0;
    logic        stb = 1'b0;
    logic [11:0] pc = '0;
    logic [15:0] ac;
    logic        e;
    logic        skip;
    logic [11:0] pc_next;
    logic        halt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [15:0] ac;
        logic        e;
        logic        skip;
        logic [11:0] pc_next;
        logic        halt;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    logic [15:0] m_ac = '0;
    logic        m_e = 1'b0;
    logic        m_halt = 1'b0;

    always #5 clk = ~clk;

    rri_exec_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_i       (ir),
        .exec_stb_i (stb),
        .pc_i       (pc),
        .ac_o       (ac),
        .e_o        (e),
        .skip_o     (skip),
        .pc_next_o  (pc_next),
        .halt_o     (halt)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Driver: apply one instruction, model it, queue the expectation.
    task automatic send(input logic [15:0] w, input logic s,
                        input logic [11:0] p, input string tag);
        exp_t x;
        logic sk;
        @(negedge clk);
        #1;
        ir = w;
        stb = s;
        pc = p;
        sk = 1'b0;
        if (s && !w[15] && w[14:12] == 3'b111 && !m_halt) begin
            if (w[11]) m_ac = 16'h0000;
            if (w[10]) m_e = 1'b0;
            if (w[9])  m_ac = ~m_ac;
            if (w[8])  m_e = ~m_e;
            if (w[7])  {m_ac, m_e} = {m_e, m_ac};
            if (w[6])  {m_e, m_ac} = {m_ac, m_e};
            if (w[5])  m_ac = m_ac + 16'h0001;
            if (w[4] && !m_ac[15] && m_ac != 0) sk = 1'b1;
            if (w[3] && m_ac[15]) sk = 1'b1;
            if (w[2] && m_ac == 0) sk = 1'b1;
            if (w[1] && !m_e) sk = 1'b1;
            if (w[0]) m_halt = 1'b1;
        end
        x.ac = m_ac;
        x.e = m_e;
        x.skip = sk;
        x.pc_next = sk ? p + 12'd1 : p;
        x.halt = m_halt;
        x.tag = tag;
        sb_q.push_back(x);
    endtask

    // Monitor: compare combinational outputs mid-cycle, state after the edge.
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                x = sb_q.pop_front();
                check(x.tag, "skip", 32'(skip), 32'(x.skip));
                check(x.tag, "pc_next", 32'(pc_next), 32'(x.pc_next));
                @(posedge clk);
                #1;
                check(x.tag, "ac", 32'(ac), 32'(x.ac));
                check(x.tag, "e", 32'(e), 32'(x.e));
                check(x.tag, "halt", 32'(halt), 32'(x.halt));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1", "ac", 32'(ac), 32'h0);
        check("R1", "e", 32'(e), 32'h0);
        check("R1", "halt", 32'(halt), 32'h0);
        check("R1", "skip", 32'(skip), 32'h0);

        send(16'h7200, 1'b1, 12'h001, "R4 CMA");
        send(16'h7800, 1'b1, 12'h002, "R3 CLA");
        send(16'h7100, 1'b1, 12'h003, "R4 CME");
        send(16'h7400, 1'b1, 12'h004, "R3 CLE");
        send(16'h7200, 1'b1, 12'h005, "R4 CMA again");
        send(16'h7008, 1'b1, 12'h010, "R7 SNA taken");
        send(16'h7010, 1'b1, 12'h011, "R7 SPA negative");
        send(16'h7020, 1'b1, 12'h012, "R6 INC wrap");
        send(16'h7004, 1'b1, 12'h013, "R7 SZA taken");
        send(16'h7010, 1'b1, 12'h014, "R7 SPA zero");
        send(16'h7008, 1'b1, 12'h015, "R7 SNA zero");
        send(16'h7020, 1'b1, 12'h016, "R6 INC one");
        send(16'h7010, 1'b1, 12'h017, "R7 SPA taken");
        send(16'h7100, 1'b1, 12'h018, "R4 CME set");
        send(16'h7020, 1'b1, 12'h019, "R6 INC keeps E");
        send(16'h7002, 1'b1, 12'h01A, "R7 SZE E set");
        send(16'h7080, 1'b1, 12'h01B, "R5 CIR");
        send(16'h7080, 1'b1, 12'h01C, "R5 CIR twice");
        send(16'h7040, 1'b1, 12'h01D, "R5 CIL");
        send(16'h7040, 1'b1, 12'h01E, "R5 CIL twice");
        send(16'h7400, 1'b1, 12'h01F, "R3 CLE clear");
        send(16'h7002, 1'b1, 12'hFFF, "R8 SZE wrap");
        send(16'h7A00, 1'b1, 12'h020, "R9 CLA then CMA");
        send(16'h7224, 1'b1, 12'h021, "R9 CMA INC SZA");
        send(16'h7804, 1'b1, 12'h022, "R9 CLA then SZA");
        send(16'h7300, 1'b1, 12'h023, "R9 CMA CME");
        send(16'hF200, 1'b1, 12'h024, "R2 MSB set");
        send(16'h6200, 1'b1, 12'h025, "R2 wrong opcode");
        send(16'h7208, 1'b0, 12'h026, "R2 no strobe");
        send(16'h7001, 1'b1, 12'h027, "R10 HLT");
        send(16'h7200, 1'b1, 12'h028, "R10 ignored CMA");
        send(16'h7004, 1'b1, 12'h029, "R10 ignored SZA");
        send(16'h0000, 1'b0, 12'h02A, "R10 idle");
        while (sb_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule